// File: doc/BRIEF.md
# Split Response Completion Tracker

This block follows the completion of a single outstanding coherent read. The completion reaches the requester in one of two shapes. In the first, data beats arrive on the data channel with the completion folded into them. In the second, a stand-alone response arrives on the response channel and data-only beats arrive on the data channel. In the second shape the response may come before, between or after the beats. The tracker records which parts have arrived and counts data beats. It raises two permissions: one to send the completion acknowledge downstream and one to pass the grant upstream.

Both permissions depend on two independent sticky conditions: "response seen" and "all data seen". Either may become true first. The tracker also keeps the staged progress flags first, last and early-grant. A neighbouring grant path decodes these flags, so their exact set rules are part of the behaviour. The last flag may become true before the response has arrived. For that reason the permissions never follow the last flag. Pulsing `alloc_i` starts a new transaction and clears every piece of state.

Top module: `split_cmpl_tracker`

## Requirements
- R1: `beat_cnt_o` is cleared by allocation. It increments by one on each accepted data beat, where a data beat has `dat_valid_i` high and `dat_opcode_i` equal to 4'hB (data-only) or 4'h4 (combined). Once it reaches BEATS (default 2), further data beats are ignored entirely and change no output.
- R2: `ack_en_o` is high exactly when a response has been seen and all BEATS data beats have been seen since the last allocation. A response means `rsp_valid_i` with `rsp_opcode_i` equal to 5'h0B, or the final combined beat. Data-only beats alone never raise it.
- R3: `first_o` is set by a separate response or by any accepted data-only beat.
- R4: `last_o` is set only by an accepted data-only beat that arrives while the counter equals BEATS-1 and `first_o` is already high before that edge. A final combined beat also sets it.
- R5: `grant_en_o` follows the same rule as `ack_en_o`. The response can arrive first, between the beats or last, and in every order the result is the same. Both permissions rise on the cycle after the edge that completes the second condition.
- R6: `early_o` is set by an accepted data-only beat when the offset latched at allocation is zero, or when `first_o` is already high. A final combined beat also sets it.
- R7: The final combined beat sets first, last, early, response-seen and all-data-seen on the same edge. Earlier combined beats only advance the counter.
- R8: Allocation clears all flags, permissions and the counter, and latches whether `alloc_off_i` is zero. Allocation has priority over any response or data event in the same cycle.
- R9: All flags and both permissions stay high until the next allocation.
- R10: Events carrying any other opcode, or with their valid low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Start of a new transaction; clears state |
| alloc_off_i | input | OFF_W | Offset of the new transaction, sampled with alloc_i |
| rsp_valid_i | input | 1 | Response channel valid |
| rsp_opcode_i | input | RSP_OP_W | Response channel opcode |
| dat_valid_i | input | 1 | Data channel valid |
| dat_opcode_i | input | DAT_OP_W | Data channel opcode |
| ack_en_o | output | 1 | Completion acknowledge may be sent |
| grant_en_o | output | 1 | Upstream grant may be sent |
| first_o | output | 1 | First part of completion received |
| last_o | output | 1 | Last data part received (staged flag) |
| early_o | output | 1 | Early-grant flag |
| beat_cnt_o | output | CNT_W | Accepted data beats since allocation |

## Verification
The hardest case to reach is a response that arrives after both data-only beats. Here `last_o` is already high but neither permission may rise. Random traffic seldom holds the response back for that long. Directed sequences therefore build each of the three orders and check the outputs after every edge. Random traffic adds same-cycle response-and-beat events, stray opcodes, surplus beats and allocations that collide with events.

// File: rtl/split_cmpl_pkg.sv
package split_cmpl_pkg;
  typedef struct packed {
    logic rsp_sep;
    logic dat_sep;
    logic dat_comb;
  } cmpl_evt_t;

  typedef enum logic [2:0] {
    FL_RSP   = 3'd0,
    FL_DATA  = 3'd1,
    FL_FIRST = 3'd2,
    FL_LAST  = 3'd3,
    FL_EARLY = 3'd4
  } cmpl_flag_e;

  localparam int unsigned NUM_FLAGS = 5;
endpackage

// File: rtl/split_cmpl_decode.sv
module split_cmpl_decode
  import split_cmpl_pkg::*;
#(
  parameter int unsigned RSP_OP_W = 5,
  parameter int unsigned DAT_OP_W = 4,
  parameter logic [RSP_OP_W-1:0] OP_RSP_SEP  = 5'h0B,
  parameter logic [DAT_OP_W-1:0] OP_DAT_SEP  = 4'hB,
  parameter logic [DAT_OP_W-1:0] OP_DAT_COMB = 4'h4
) (
  input  logic                rsp_valid,
  input  logic [RSP_OP_W-1:0] rsp_opcode,
  input  logic                dat_valid,
  input  logic [DAT_OP_W-1:0] dat_opcode,
  output cmpl_evt_t           evt
);
  always_comb begin
    evt.rsp_sep  = rsp_valid && (rsp_opcode == OP_RSP_SEP);
    evt.dat_sep  = dat_valid && (dat_opcode == OP_DAT_SEP);
    evt.dat_comb = dat_valid && (dat_opcode == OP_DAT_COMB);
  end
endmodule

// File: rtl/split_cmpl_beat_ctr.sv
module split_cmpl_beat_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/split_cmpl_sticky.sv
module split_cmpl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = clr || set;
    q_d  = !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/split_cmpl_tracker.sv
module split_cmpl_tracker
  import split_cmpl_pkg::*;
#(
  parameter int unsigned BEATS    = 2,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned RSP_OP_W = 5,
  parameter int unsigned DAT_OP_W = 4,
  parameter logic [RSP_OP_W-1:0] OP_RSP_SEP  = 5'h0B,
  parameter logic [DAT_OP_W-1:0] OP_DAT_SEP  = 4'hB,
  parameter logic [DAT_OP_W-1:0] OP_DAT_COMB = 4'h4,
  localparam int unsigned CNT_W = $clog2(BEATS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_i,
  input  logic [OFF_W-1:0]    alloc_off_i,
  input  logic                rsp_valid_i,
  input  logic [RSP_OP_W-1:0] rsp_opcode_i,
  input  logic                dat_valid_i,
  input  logic [DAT_OP_W-1:0] dat_opcode_i,
  output logic                ack_en_o,
  output logic                grant_en_o,
  output logic                first_o,
  output logic                last_o,
  output logic                early_o,
  output logic [CNT_W-1:0]    beat_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FINAL = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(BEATS);

  cmpl_evt_t              evt;
  logic [NUM_FLAGS-1:0]   flag_set;
  logic [NUM_FLAGS-1:0]   flag_q;
  logic                   sep_beat, comb_beat, any_beat, at_final, comb_last;
  logic                   offz_q, offz_d, offz_en;

  split_cmpl_decode #(
    .RSP_OP_W   (RSP_OP_W),
    .DAT_OP_W   (DAT_OP_W),
    .OP_RSP_SEP (OP_RSP_SEP),
    .OP_DAT_SEP (OP_DAT_SEP),
    .OP_DAT_COMB(OP_DAT_COMB)
  ) u_decode (
    .rsp_valid (rsp_valid_i),
    .rsp_opcode(rsp_opcode_i),
    .dat_valid (dat_valid_i),
    .dat_opcode(dat_opcode_i),
    .evt       (evt)
  );

  // Accept logic: beats past the expected count are dropped.
  always_comb begin
    at_final  = (beat_cnt_o == CNT_FINAL);
    sep_beat  = evt.dat_sep  && (beat_cnt_o != CNT_FULL);
    comb_beat = evt.dat_comb && (beat_cnt_o != CNT_FULL);
    any_beat  = sep_beat || comb_beat;
    comb_last = comb_beat && at_final;
  end

  // Flag set rules; the first flag is sampled before this edge.
  always_comb begin
    flag_set           = '0;
    flag_set[FL_RSP]   = evt.rsp_sep || comb_last;
    flag_set[FL_DATA]  = any_beat && at_final;
    flag_set[FL_FIRST] = evt.rsp_sep || sep_beat || comb_last;
    flag_set[FL_LAST]  = (sep_beat && at_final && flag_q[FL_FIRST]) || comb_last;
    flag_set[FL_EARLY] = (sep_beat && (offz_q || flag_q[FL_FIRST])) || comb_last;
  end

  split_cmpl_beat_ctr #(.CNT_W(CNT_W)) u_beat_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (alloc_i),
    .inc  (any_beat),
    .cnt  (beat_cnt_o)
  );

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    split_cmpl_sticky u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (alloc_i),
      .set  (flag_set[gi]),
      .q    (flag_q[gi])
    );
  end

  always_comb begin
    offz_en = alloc_i;
    offz_d  = (alloc_off_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       offz_q <= 1'b0;
    else if (offz_en) offz_q <= offz_d;
  end

  always_comb begin
    ack_en_o   = flag_q[FL_RSP] && flag_q[FL_DATA];
    grant_en_o = flag_q[FL_RSP] && flag_q[FL_DATA];
    first_o    = flag_q[FL_FIRST];
    last_o     = flag_q[FL_LAST];
    early_o    = flag_q[FL_EARLY];
  end
endmodule

// File: rtl/split_cmpl_tracker_chk.sv
module split_cmpl_tracker_chk #(
  parameter int unsigned BEATS    = 2,
  parameter int unsigned RSP_OP_W = 5,
  parameter int unsigned DAT_OP_W = 4,
  parameter logic [RSP_OP_W-1:0] OP_RSP_SEP  = 5'h0B,
  parameter logic [DAT_OP_W-1:0] OP_DAT_SEP  = 4'hB,
  parameter logic [DAT_OP_W-1:0] OP_DAT_COMB = 4'h4,
  parameter int unsigned CNT_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_i,
  input logic                rsp_valid_i,
  input logic [RSP_OP_W-1:0] rsp_opcode_i,
  input logic                dat_valid_i,
  input logic [DAT_OP_W-1:0] dat_opcode_i,
  input logic                ack_en_o,
  input logic                grant_en_o,
  input logic                first_o,
  input logic                last_o,
  input logic [CNT_W-1:0]    beat_cnt_o
);
  localparam int unsigned SW = CNT_W + 1;
  logic [SW-1:0] seen_beats;
  logic          seen_rsp;
  logic          beat_evt;

  assign beat_evt = dat_valid_i && ((dat_opcode_i == OP_DAT_SEP) || (dat_opcode_i == OP_DAT_COMB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_beats <= '0;
      seen_rsp   <= 1'b0;
    end else if (alloc_i) begin
      seen_beats <= '0;
      seen_rsp   <= 1'b0;
    end else begin
      if (beat_evt && seen_beats < SW'(BEATS)) seen_beats <= seen_beats + 1'b1;
      if (rsp_valid_i && rsp_opcode_i == OP_RSP_SEP) seen_rsp <= 1'b1;
      if (beat_evt && dat_opcode_i == OP_DAT_COMB && seen_beats == SW'(BEATS - 1)) seen_rsp <= 1'b1;
    end
  end

  assert_ack_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_o |-> (seen_rsp && seen_beats == SW'(BEATS)));
  assert_grant_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en_o == ack_en_o);
  assert_last_after_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_o) |-> ($past(first_o) || first_o));
  assert_alloc_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (!ack_en_o && !first_o && !last_o && beat_cnt_o == '0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_en_o && !alloc_i) |=> grant_en_o);
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt_o <= CNT_W'(BEATS));
endmodule

bind split_cmpl_tracker split_cmpl_tracker_chk #(
  .BEATS(BEATS), .RSP_OP_W(RSP_OP_W), .DAT_OP_W(DAT_OP_W),
  .OP_RSP_SEP(OP_RSP_SEP), .OP_DAT_SEP(OP_DAT_SEP), .OP_DAT_COMB(OP_DAT_COMB),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i),
  .rsp_valid_i(rsp_valid_i), .rsp_opcode_i(rsp_opcode_i),
  .dat_valid_i(dat_valid_i), .dat_opcode_i(dat_opcode_i),
  .ack_en_o(ack_en_o), .grant_en_o(grant_en_o),
  .first_o(first_o), .last_o(last_o), .beat_cnt_o(beat_cnt_o)
);

// File: tb/split_cmpl_tracker_bench.sv
module split_cmpl_tracker_bench;
  localparam int BEATS = 2;
  localparam logic [4:0] RSP_SEP = 5'h0B;
  localparam logic [3:0] DAT_SEP = 4'hB;
  localparam logic [3:0] DAT_COMB = 4'h4;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_i;
  logic [1:0] alloc_off_i;
  logic rsp_valid_i;
  logic [4:0] rsp_opcode_i;
  logic dat_valid_i;
  logic [3:0] dat_opcode_i;
  logic ack_en_o, grant_en_o, first_o, last_o, early_o;
  logic [1:0] beat_cnt_o;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int  m_cnt;
  bit  m_rsp, m_data, m_first, m_last, m_early, m_offz;

  always #4 clk = ~clk;

  split_cmpl_tracker u_split_cmpl_tracker (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .alloc_off_i(alloc_off_i),
    .rsp_valid_i(rsp_valid_i), .rsp_opcode_i(rsp_opcode_i),
    .dat_valid_i(dat_valid_i), .dat_opcode_i(dat_opcode_i),
    .ack_en_o(ack_en_o), .grant_en_o(grant_en_o), .first_o(first_o),
    .last_o(last_o), .early_o(early_o), .beat_cnt_o(beat_cnt_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit enable_exp();
    return m_rsp && m_data;
  endfunction

  task automatic model(input bit al, input bit [1:0] off, input bit rv, input bit [4:0] ro,
                       input bit dv, input bit [3:0] dop);
    bit rs, sb, cb, fin, cl, f0;
    if (al) begin
      m_cnt = 0; m_rsp = 0; m_data = 0; m_first = 0; m_last = 0; m_early = 0;
      m_offz = (off == 0);
      return;
    end
    f0  = m_first;
    rs  = rv && ro == RSP_SEP;
    sb  = dv && dop == DAT_SEP && m_cnt < BEATS;
    cb  = dv && dop == DAT_COMB && m_cnt < BEATS;
    fin = (m_cnt == BEATS - 1);
    cl  = cb && fin;
    if (rs || cl) m_rsp = 1;
    if ((sb || cb) && fin) m_data = 1;
    if (rs || sb || cl) m_first = 1;
    if ((sb && fin && f0) || cl) m_last = 1;
    if ((sb && (m_offz || f0)) || cl) m_early = 1;
    if (sb || cb) m_cnt++;
  endtask

  task automatic compare_all();
    check("R1 beat_cnt", beat_cnt_o, m_cnt);
    check("R2 ack_en", ack_en_o, enable_exp());
    check("R5 grant_en", grant_en_o, enable_exp());
    check("R3 first", first_o, m_first);
    check("R4 last", last_o, m_last);
    check("R6 early", early_o, m_early);
  endtask

  // Called at a negedge: drive, clock, model, compare at next negedge.
  task automatic step(input bit al, input bit [1:0] off, input bit rv, input bit [4:0] ro,
                      input bit dv, input bit [3:0] dop);
    alloc_i = al; alloc_off_i = off;
    rsp_valid_i = rv; rsp_opcode_i = ro;
    dat_valid_i = dv; dat_opcode_i = dop;
    @(posedge clk);
    model(al, off, rv, ro, dv, dop);
    @(negedge clk);
    alloc_i = 0; rsp_valid_i = 0; dat_valid_i = 0;
    compare_all();
  endtask

  task automatic do_alloc(input bit [1:0] off); step(1, off, 0, 0, 0, 0); endtask
  task automatic do_rsp();  step(0, 0, 1, RSP_SEP, 0, 0); endtask
  task automatic do_beat(); step(0, 0, 0, 0, 1, DAT_SEP); endtask
  task automatic do_comb(); step(0, 0, 0, 0, 1, DAT_COMB); endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd5150;
    void'($urandom(seed));
    rst_n = 0; alloc_i = 0; alloc_off_i = 0; rsp_valid_i = 0; rsp_opcode_i = 0;
    dat_valid_i = 0; dat_opcode_i = 0;
    m_cnt = 0; m_rsp = 0; m_data = 0; m_first = 0; m_last = 0; m_early = 0; m_offz = 0;
    repeat (3) @(negedge clk);
    compare_all();               // reset state (R8)
    rst_n = 1;
    @(negedge clk);

    // Order A: response first (R5)
    do_alloc(2'd1);
    do_rsp();   check("R5 rsp-first no early ack", ack_en_o, 0);
    do_beat();  check("R5 rsp-first no early grant", grant_en_o, 0);
    do_beat();  check("R5 rsp-first grant", grant_en_o, 1);
    // Order B: response between beats
    do_alloc(2'd1);
    do_beat();  check("R6 early not set, off nonzero", early_o, 0);
    do_rsp();   check("R2 ack low mid", ack_en_o, 0);
    do_beat();  check("R5 between grant", grant_en_o, 1);
    check("R6 early after first", early_o, 1);
    // Order C: response last; last flag up, enables down
    do_alloc(2'd2);
    do_beat();
    do_beat();  check("R4 last before rsp", last_o, 1);
    check("R2 data-only never acks", ack_en_o, 0);
    do_beat();  check("R1 extra beat ignored", beat_cnt_o, 2);
    do_rsp();   check("R5 rsp-last grant", grant_en_o, 1);
    do_alloc(2'd0); check("R8 alloc clears", grant_en_o, 0);
    // Sticky and ignored opcodes
    do_beat();  check("R6 offset zero early", early_o, 1);
    step(0, 0, 1, 5'h03, 1, 4'h7); check("R10 stray opcodes", beat_cnt_o, 1);
    do_rsp(); do_beat();
    step(0, 0, 0, 0, 0, 0); check("R9 sticky", ack_en_o, 1);
    // Combined path
    do_alloc(2'd3);
    do_comb();  check("R7 non-final comb no flag", first_o, 0);
    do_comb();  check("R7 final comb sets all", {ack_en_o, first_o, last_o, early_o}, 4'hF);
    // Alloc collides with events
    step(1, 2'd1, 1, RSP_SEP, 1, DAT_SEP); check("R8 alloc priority", beat_cnt_o, 0);
    // Same-cycle rsp and beat
    step(0, 0, 1, RSP_SEP, 1, DAT_SEP);
    do_beat(); check("R5 simultaneous", grant_en_o, 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      bit al, rv, dv;
      bit [4:0] ro;
      bit [3:0] dop;
      int r;
      al = ($urandom % 9) == 0;
      rv = ($urandom % 4) == 0;
      dv = ($urandom % 2) == 0;
      r = $urandom % 8;
      ro = (r < 6) ? RSP_SEP : 5'($urandom);
      r = $urandom % 8;
      dop = (r < 4) ? DAT_SEP : (r < 6) ? DAT_COMB : 4'($urandom);
      step(al, 2'($urandom), rv, ro, dv, dop);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule